// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Status Flags

This block sends bytes over an asynchronous serial line. A one-entry holding register sits in front of a shift register, so software can queue the next value while the current frame is still going out. When a frame ends and a value is waiting, the waiting value starts on the very next bit period, with no idle time on the line. Bit timing comes from an external single-cycle baud tick. Each tick advances the line by one bit.

Two status flags report progress. The empty flag shows that the holding register can take a new value. The done flag shows that the line has gone idle with nothing queued. Each flag drives an interrupt request. The request is gated by the flag's own enable and by a global enable. Software can clear either flag by writing a zero to it, and writing a one has no effect. The done flag is also cleared by an interrupt acknowledge pulse.

The frame shape is taken when a frame starts: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Dropping the enable stops further frames only after the current frame has ended. At that point `tx_active` falls.

Top module: `serial_tx_dbuf`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `txd` is 1, `buf_empty` is 1, `tx_done` is 0 and both interrupt requests are 0. `tx_active` is 0 while `tx_en` is 0.
- R2: A frame has the following parts, in order. A start bit of 0. Then N data bits, least significant bit first, where N = 5 + `data_sel` (`data_sel` 0..3 gives 5..8). Then the stop bits, which are 1: one stop bit when `two_stop` is 0, two when it is 1. Each bit changes only on the clock edge that samples `baud_tick` high. The line is 1 while idle.
- R3: When `parity_mode[1]` is 1, one parity bit is sent after the last data bit and before the first stop bit. `parity_mode[0]` = 0 gives even parity and 1 gives odd parity: the parity bit is the XOR of the N data bits, XORed with `parity_mode[0]`. When `parity_mode[1]` is 0, no parity bit is sent.
- R4: A `wr_data` pulse clears `buf_empty` in the next cycle. When the queued value moves into the shift register, which happens on a baud tick while the shifter is idle or ending a frame and `tx_en` is 1, `buf_empty` is set again.
- R5: A `flag_wr` strobe with `flag_wdata_empty` = 0 clears `buf_empty`, and one with `flag_wdata_done` = 0 clears `tx_done`. A data bit of 1 leaves the matching flag unchanged.
- R6: `tx_done` is set on the tick that ends a frame's last stop bit, when no new frame starts on that tick. It stays 0 when a queued value follows at once. A `done_ack` pulse clears it.
- R7: When a value is queued before a frame ends, its start bit goes out on the tick that ends the previous frame's last stop bit.
- R8: `irq_empty` equals `buf_empty & empty_ie & gie`, and `irq_done` equals `tx_done & done_ie & gie`.
- R9: Clearing `tx_en` during a frame lets that frame finish intact. No queued value is sent while `tx_en` is 0. `tx_active` is 1 while `tx_en` is 1 or a frame is in progress, and falls once the last frame has ended with `tx_en` at 0.
- R10: `data_sel`, `parity_mode` and `two_stop` are captured when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| gie | input | 1 | Global interrupt enable |
| empty_ie | input | 1 | Enable for the empty-flag interrupt |
| done_ie | input | 1 | Enable for the done-flag interrupt |
| data_sel | input | 2 | Data length, 5 + value bits |
| parity_mode | input | 2 | [1] parity on, [0] odd |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_data | input | 1 | Write strobe for the holding register |
| wr_value | input | 8 | Value to queue |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata_empty | input | 1 | Written value for the empty flag (0 clears) |
| flag_wdata_done | input | 1 | Written value for the done flag (0 clears) |
| done_ack | input | 1 | Interrupt acknowledge for the done flag |
| txd | output | 1 | Serial output |
| tx_active | output | 1 | Transmitter owns the line |
| buf_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Empty-flag interrupt request |
| irq_done | output | 1 | Done-flag interrupt request |

## Verification
The hardest cases to reach are two hand-offs at the end of a frame. In the first, a queued value has to start on the same tick that ends the last stop bit. In the second, the enable is dropped in the middle of a frame. The bench reaches both by watching the line for the start bit of the current frame. It then queues a second value, or lowers `tx_en`, or changes the frame settings, while that frame is still shifting. After that it checks every bit of the rest of the frame and the tick that follows it.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;
    localparam int SEL_W    = 2;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } sh_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] last_idx;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } frame_cfg_t;

    function automatic logic [IDX_W-1:0] last_index(input logic [SEL_W-1:0] sel);
        return IDX_W'(MIN_BITS - 1) + IDX_W'(sel);
    endfunction

    function automatic logic calc_parity(input logic [MAX_BITS-1:0] d,
                                         input logic [IDX_W-1:0]    last,
                                         input logic                odd);
        logic p;
        p = odd;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i <= int'(last)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/stx_holdbuf.sv
module stx_holdbuf
    import stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [MAX_BITS-1:0] wdata,
    input  logic                load,
    input  logic                flag_wr,
    input  logic                flag_bit,
    output logic                full,
    output logic [MAX_BITS-1:0] data,
    output logic                empty_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full       <= 1'b0;
            data       <= '0;
            empty_flag <= 1'b1;
        end else begin
            if (wr) begin
                full <= 1'b1;
                data <= wdata;
            end else if (load) begin
                full <= 1'b0;
            end

            if (wr)
                empty_flag <= 1'b0;
            else if (load)
                empty_flag <= 1'b1;
            else if (flag_wr && !flag_bit)
                empty_flag <= 1'b0;
        end
    end

    p_write_clears_empty_r4: assert property (@(posedge clk) disable iff (rst)
        wr |=> !empty_flag);

    p_load_sets_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (load && !wr) |=> empty_flag);

    p_write_one_noeffect_r5: assert property (@(posedge clk) disable iff (rst)
        (!empty_flag && flag_wr && flag_bit && !load) |=> !empty_flag);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                tx_en,
    input  logic                hb_full,
    input  logic [MAX_BITS-1:0] hb_data,
    input  frame_cfg_t          cfg_in,
    output logic                load,
    output logic                done_set,
    output logic                busy,
    output logic                txd
);

    sh_state_e           state;
    logic [MAX_BITS-1:0] shreg;
    logic [IDX_W-1:0]    idx;
    logic                stop_cnt;
    logic                par_bit;
    frame_cfg_t          cfg;
    logic                end_of_frame;

    assign end_of_frame = (state == S_STOP) && (!cfg.two_stop || stop_cnt);
    assign load         = tick && hb_full && tx_en && ((state == S_IDLE) || end_of_frame);
    assign done_set     = tick && end_of_frame && !load;
    assign busy         = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            shreg    <= '0;
            idx      <= '0;
            stop_cnt <= 1'b0;
            par_bit  <= 1'b0;
            cfg      <= '0;
            txd      <= 1'b1;
        end else if (tick) begin
            if (load) begin
                state   <= S_START;
                txd     <= 1'b0;
                shreg   <= hb_data;
                cfg     <= cfg_in;
                par_bit <= calc_parity(hb_data, cfg_in.last_idx, cfg_in.par_odd);
            end else begin
                case (state)
                    S_IDLE: begin
                        txd <= 1'b1;
                    end
                    S_START: begin
                        txd   <= shreg[0];
                        shreg <= shreg >> 1;
                        idx   <= '0;
                        state <= S_DATA;
                    end
                    S_DATA: begin
                        if (idx == cfg.last_idx) begin
                            if (cfg.par_en) begin
                                state <= S_PAR;
                                txd   <= par_bit;
                            end else begin
                                state    <= S_STOP;
                                txd      <= 1'b1;
                                stop_cnt <= 1'b0;
                            end
                        end else begin
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                            idx   <= idx + 1'b1;
                        end
                    end
                    S_PAR: begin
                        state    <= S_STOP;
                        txd      <= 1'b1;
                        stop_cnt <= 1'b0;
                    end
                    S_STOP: begin
                        if (end_of_frame) begin
                            state <= S_IDLE;
                            txd   <= 1'b1;
                        end else begin
                            stop_cnt <= 1'b1;
                        end
                    end
                    default: begin
                        state <= S_IDLE;
                        txd   <= 1'b1;
                    end
                endcase
            end
        end
    end

    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_START) |-> !txd);

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(txd));

    p_stop_bits_high_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_STOP) |-> txd);

endmodule

// File: rtl/stx_flags.sv
module stx_flags (
    input  logic clk,
    input  logic rst,
    input  logic done_set,
    input  logic ack,
    input  logic flag_wr,
    input  logic flag_bit,
    input  logic empty_flag,
    input  logic gie,
    input  logic empty_ie,
    input  logic done_ie,
    output logic done_flag,
    output logic irq_empty,
    output logic irq_done
);

    always_ff @(posedge clk) begin
        if (rst)
            done_flag <= 1'b0;
        else if (done_set)
            done_flag <= 1'b1;
        else if (ack)
            done_flag <= 1'b0;
        else if (flag_wr && !flag_bit)
            done_flag <= 1'b0;
    end

    assign irq_empty = empty_flag & empty_ie & gie;
    assign irq_done  = done_flag & done_ie & gie;

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !done_set) |=> !done_flag);

    p_done_write_one_r5: assert property (@(posedge clk) disable iff (rst)
        (done_flag && flag_wr && flag_bit && !ack) |=> done_flag);

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
    import stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                baud_tick,
    input  logic                tx_en,
    input  logic                gie,
    input  logic                empty_ie,
    input  logic                done_ie,
    input  logic [SEL_W-1:0]    data_sel,
    input  logic [1:0]          parity_mode,
    input  logic                two_stop,
    input  logic                wr_data,
    input  logic [MAX_BITS-1:0] wr_value,
    input  logic                flag_wr,
    input  logic                flag_wdata_empty,
    input  logic                flag_wdata_done,
    input  logic                done_ack,
    output logic                txd,
    output logic                tx_active,
    output logic                buf_empty,
    output logic                tx_done,
    output logic                irq_empty,
    output logic                irq_done
);

    logic                hb_full;
    logic [MAX_BITS-1:0] hb_data;
    logic                load;
    logic                done_set;
    logic                busy;
    frame_cfg_t          cfg_now;

    always_comb begin
        cfg_now.last_idx = last_index(data_sel);
        cfg_now.par_en   = parity_mode[1];
        cfg_now.par_odd  = parity_mode[0];
        cfg_now.two_stop = two_stop;
    end

    stx_holdbuf u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_data),
        .wdata      (wr_value),
        .load       (load),
        .flag_wr    (flag_wr),
        .flag_bit   (flag_wdata_empty),
        .full       (hb_full),
        .data       (hb_data),
        .empty_flag (buf_empty)
    );

    stx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .tx_en    (tx_en),
        .hb_full  (hb_full),
        .hb_data  (hb_data),
        .cfg_in   (cfg_now),
        .load     (load),
        .done_set (done_set),
        .busy     (busy),
        .txd      (txd)
    );

    stx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .done_set   (done_set),
        .ack        (done_ack),
        .flag_wr    (flag_wr),
        .flag_bit   (flag_wdata_done),
        .empty_flag (buf_empty),
        .gie        (gie),
        .empty_ie   (empty_ie),
        .done_ie    (done_ie),
        .done_flag  (tx_done),
        .irq_empty  (irq_empty),
        .irq_done   (irq_done)
    );

    assign tx_active = tx_en | busy;

    p_done_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> !busy);

    p_no_start_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(tx_en) && !$past(busy)) |-> !busy);

endmodule

// File: tb/sim_serial_tx_dbuf.sv
`timescale 1ns/1ps
module sim_serial_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       gie = 1'b0;
    logic       empty_ie = 1'b0;
    logic       done_ie = 1'b0;
    logic [1:0] data_sel = 2'd3;
    logic [1:0] parity_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wr_value = 8'h00;
    logic       flag_wr = 1'b0;
    logic       flag_wdata_empty = 1'b1;
    logic       flag_wdata_done = 1'b1;
    logic       done_ack = 1'b0;
    logic       txd, tx_active, buf_empty, tx_done, irq_empty, irq_done;

    int nchk = 0;
    int nfail = 0;
    int tcnt = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 3);
    end

    serial_tx_dbuf u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en), .gie(gie),
        .empty_ie(empty_ie), .done_ie(done_ie), .data_sel(data_sel),
        .parity_mode(parity_mode), .two_stop(two_stop), .wr_data(wr_data),
        .wr_value(wr_value), .flag_wr(flag_wr), .flag_wdata_empty(flag_wdata_empty),
        .flag_wdata_done(flag_wdata_done), .done_ack(done_ack), .txd(txd),
        .tx_active(tx_active), .buf_empty(buf_empty), .tx_done(tx_done),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_bit();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data  = 1'b1;
        wr_value = d;
        @(negedge clk);
        wr_data  = 1'b0;
        chk(buf_empty == 1'b0, "R4 write clears empty", buf_empty, 0);
    endtask

    task automatic ack_done();
        @(negedge clk);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk(tx_done == 1'b0, "R6 ack clears done", tx_done, 0);
    endtask

    task automatic flag_write(input logic e, input logic d);
        @(negedge clk);
        flag_wr = 1'b1;
        flag_wdata_empty = e;
        flag_wdata_done = d;
        @(negedge clk);
        flag_wr = 1'b0;
    endtask

    task automatic recv(input logic [7:0] d, input int n, input logic [1:0] pm,
                        input logic ts, input bit immediate, input bit last,
                        input bit drop_en, input bit poke);
        bit got = 0;
        int guard = 0;
        logic p;
        if (immediate) begin
            wait_bit();
            chk(txd == 1'b0, "R7 queued start follows stop", txd, 0);
            chk(tx_done == 1'b0, "R6 done stays low on hand-off", tx_done, 0);
            got = 1;
        end else begin
            while (!got && guard < 6) begin
                wait_bit();
                guard++;
                if (txd == 1'b0) got = 1;
            end
            chk(got, "R2 start bit seen", got, 1);
        end
        chk(buf_empty == 1'b1, "R4 transfer sets empty", buf_empty, 1);
        if (drop_en) tx_en = 1'b0;
        if (poke) begin
            data_sel    = 2'd0;
            parity_mode = 2'b11;
            two_stop    = ~ts;
        end
        for (int i = 0; i < n; i++) begin
            wait_bit();
            chk(txd == d[i], "R2 data bit", txd, d[i]);
        end
        if (drop_en) chk(tx_active == 1'b1, "R9 active during frame", tx_active, 1);
        if (pm[1]) begin
            p = pm[0];
            for (int i = 0; i < n; i++) p = p ^ d[i];
            wait_bit();
            chk(txd == p, "R3 parity bit", txd, p);
        end
        for (int s = 0; s < (ts ? 2 : 1); s++) begin
            wait_bit();
            chk(txd == 1'b1, "R2 stop bit", txd, 1);
        end
        if (last) begin
            wait_bit();
            chk(txd == 1'b1, "R2 idle after frame", txd, 1);
            chk(tx_done == 1'b1, "R6 done set at frame end", tx_done, 1);
            if (drop_en) chk(tx_active == 1'b0, "R9 active falls", tx_active, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a;
        logic [7:0] b;
        logic [1:0] pms [3];
        pms[0] = 2'b00; pms[1] = 2'b10; pms[2] = 2'b11;

        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && buf_empty == 1'b1 && tx_done == 1'b0, "R1 reset flags",
            {txd, buf_empty, tx_done}, 3'b110);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(irq_empty == 1'b0 && irq_done == 1'b0 && tx_active == 1'b0, "R1 reset outputs",
            {irq_empty, irq_done, tx_active}, 0);
        chk(txd == 1'b1 && buf_empty == 1'b1, "R1 after reset", {txd, buf_empty}, 3);

        tx_en = 1'b1;
        // R2 R3 R4 R6: sweep over lengths, parity modes, stop counts
        for (int sel = 0; sel < 4; sel++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    for (int k = 0; k < 2; k++) begin
                        v = 8'((sel * 37 + pi * 53 + ts * 11 + k * 91) ^ 8'hA5);
                        data_sel    = 2'(sel);
                        parity_mode = pms[pi];
                        two_stop    = 1'(ts);
                        ack_done();
                        put_byte(v);
                        recv(v, 5 + sel, pms[pi], 1'(ts), 0, 1, 0, 0);
                    end
                end
            end
        end

        // R7: back-to-back frames
        data_sel = 2'd3; parity_mode = 2'b10; two_stop = 1'b0;
        ack_done();
        a = 8'h3C; b = 8'hC5;
        put_byte(a);
        begin
            bit got = 0;
            int g = 0;
            while (!got && g < 6) begin wait_bit(); g++; if (txd == 1'b0) got = 1; end
            chk(got, "R7 first start", got, 1);
        end
        put_byte(b);
        for (int i = 0; i < 8; i++) begin
            wait_bit();
            chk(txd == a[i], "R7 first frame data", txd, a[i]);
        end
        wait_bit();
        chk(txd == ^a, "R3 even parity first frame", txd, ^a);
        wait_bit();
        chk(txd == 1'b1, "R7 first stop", txd, 1);
        recv(b, 8, 2'b10, 1'b0, 1, 1, 0, 0);

        // R10: settings changed mid-frame
        data_sel = 2'd3; parity_mode = 2'b00; two_stop = 1'b0;
        ack_done();
        put_byte(8'h96);
        recv(8'h96, 8, 2'b00, 1'b0, 0, 1, 0, 1);
        chk(1'b1, "R10 frame kept its settings", 1, 1);

        // R9: disable mid-frame, then queued value held
        data_sel = 2'd2; parity_mode = 2'b11; two_stop = 1'b1;
        ack_done();
        put_byte(8'h5A);
        recv(8'h5A, 7, 2'b11, 1'b1, 0, 1, 1, 0);
        put_byte(8'hE1);
        for (int t = 0; t < 15; t++) begin
            wait_bit();
            chk(txd == 1'b1, "R9 no send while disabled", txd, 1);
        end
        chk(buf_empty == 1'b0 && tx_active == 1'b0, "R9 value held, line released",
            {buf_empty, tx_active}, 0);
        tx_en = 1'b1;
        ack_done();
        recv(8'hE1, 7, 2'b11, 1'b1, 0, 1, 0, 0);

        // R8: interrupt gating, both flags set
        chk(buf_empty == 1'b1 && tx_done == 1'b1, "R8 flags set for sweep",
            {buf_empty, tx_done}, 3);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            gie = c[0]; empty_ie = c[1]; done_ie = c[2];
            #1;
            chk(irq_empty == (c[0] & c[1]), "R8 empty request", irq_empty, c[0] & c[1]);
            chk(irq_done == (c[0] & c[2]), "R8 done request", irq_done, c[0] & c[2]);
        end

        // R5: write-one leaves flags, write-zero clears
        flag_write(1'b1, 1'b1);
        chk(buf_empty == 1'b1 && tx_done == 1'b1, "R5 write one no effect",
            {buf_empty, tx_done}, 3);
        flag_write(1'b0, 1'b1);
        chk(buf_empty == 1'b0 && tx_done == 1'b1, "R5 clear empty only",
            {buf_empty, tx_done}, 1);
        chk(irq_empty == 1'b0 && irq_done == 1'b1, "R8 requests follow flags",
            {irq_empty, irq_done}, 1);
        flag_write(1'b1, 1'b0);
        chk(tx_done == 1'b0 && irq_done == 1'b0, "R5 clear done", tx_done, 0);
        flag_write(1'b1, 1'b1);
        chk(buf_empty == 1'b0 && tx_done == 1'b0, "R5 write one cannot set",
            {buf_empty, tx_done}, 0);
        repeat (10) wait_bit();
        chk(buf_empty == 1'b0 && txd == 1'b1, "R5 cleared empty stays low idle",
            {buf_empty, txd}, 1);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule